// File: doc/BRIEF.md
# Boot ROM Shadowing Strobe Controller

This block steers the memory strobes of a small processor board so that the code in a slow boot ROM can be moved into RAM that sits at the same addresses. It starts in a shadowing mode. In that mode every CPU read is served by the ROM, and the same read strobe also drives the RAM write enable. The data the ROM places on the bus is therefore stored in RAM at that address. A software loop that reads once through the ROM range leaves a full copy in RAM.

Software then sets a single control bit, which arrives from an I/O-space output latch. The block then enters its run mode. In run mode the ROM is switched off, the RAM answers reads, and CPU writes reach the RAM. While the block is shadowing, a read cycle starts with a short ready-low window, which adds wait states for the slow ROM. A mode change takes effect only on a clock edge at which no strobe is active, so a single access never straddles the two modes.

Top module: `shadow_boot_ctrl`

## Requirements
- R1: While reset is low, and after reset is released with the control bit low, the block is in shadowing mode (a read then gives rom_oe_n=0, ram_we_n=0, ram_oe_n=1).
- R2: In shadowing mode, rom_oe_n and ram_we_n each equal rd_n, and ram_oe_n is held at 1.
- R3: In shadowing mode the CPU write strobe has no effect: with we_n=0 and rd_n=1, all three memory strobes stay at 1.
- R4: In run mode, rom_oe_n is held at 1, ram_oe_n equals rd_n, and ram_we_n equals we_n.
- R5: A control bit of 1 puts the block in run mode at the first rising clock edge at which rd_n and we_n are both 1.
- R6: A control bit of 0 puts the block back in shadowing mode at the first rising clock edge at which rd_n and we_n are both 1.
- R7: In shadowing mode, ready is 0 from the start of a read until WAIT_STATES rising edges have sampled rd_n low. It is then 1 until the read ends. The default is one edge.
- R8: In run mode, ready stays at 1.
- R9: A change of the control bit while rd_n or we_n is 0 does not change the mode until the strobes have returned to 1.
- R10: rom_oe_n and ram_oe_n are never both 0.
- R11: Reset forces shadowing mode even when the control bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_n | input | 1 | CPU read strobe, active low |
| we_n | input | 1 | CPU write strobe, active low |
| run_sel | input | 1 | Control bit from the I/O output latch: 1 requests run mode |
| rom_oe_n | output | 1 | ROM output enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ready | output | 1 | CPU ready; 0 inserts a wait state |

## Verification
The bench builds the block with its default of WAIT_STATES=1. This puts the single-clock ROM wait in reach, and the bench can observe where the window starts and where it ends. Stimulus changes on the falling clock edge, and the bench samples just after. As a result, each check shows whether a mode request was taken at the previous rising edge or held back by an active strobe. The two mode transitions, the deferred switch, and a reset issued in run mode with the control bit still set all follow one another in a single run.

// File: rtl/sbc_pkg.sv
// Shared types for the boot ROM shadowing controller.
// Assumes nothing beyond a 1-bit mode encoding.
package sbc_pkg;
    typedef enum logic {
        MODE_UNDER = 1'b0,   // reads from ROM, copied into RAM
        MODE_RUN   = 1'b1    // RAM serves reads and writes
    } sbc_mode_t;
endpackage

// File: rtl/sbc_mode_reg.sv
// Holds the current memory mode. Loads the requested mode only on an
// edge where the bus is idle, so no strobe spans a mode change.
// Assumes rd_n/we_n are synchronous to clk.
module sbc_mode_reg
    import sbc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rd_n,
    input  logic      we_n,
    input  logic      run_sel,
    output sbc_mode_t mode
);
    logic bus_idle;

    // Bus is idle when neither strobe is active.
    always_comb bus_idle = rd_n & we_n;

    // Mode register: reset to shadowing, update only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= MODE_UNDER;
        else if (bus_idle)
            mode <= run_sel ? MODE_RUN : MODE_UNDER;
    end

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !we_n) |=> $stable(mode));

    // R11
    reset_mode_chk: assert property (@(posedge clk)
        !rst_n |=> mode == MODE_UNDER);
endmodule

// File: rtl/sbc_wait_gen.sv
// Generates the ready signal. In shadowing mode the start of each read
// holds ready low for WAIT_STATES clocks; run mode never waits.
// Assumes the mode cannot change while rd_n is low.
module sbc_wait_gen
    import sbc_pkg::*;
#(
    parameter int WAIT_STATES = 1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rd_n,
    input  sbc_mode_t mode,
    output logic      ready
);
    localparam int CW = (WAIT_STATES < 1) ? 1 : $clog2(WAIT_STATES + 1);
    localparam logic [CW-1:0] WLIM = CW'(WAIT_STATES);

    generate
        if (WAIT_STATES == 0) begin : g_nowait
            // No wait states configured: always ready.
            always_comb ready = 1'b1;
        end else begin : g_wait
            logic [CW-1:0] rd_cnt;

            // Counts edges that sampled rd_n low, saturating at the limit.
            always_ff @(posedge clk) begin
                if (!rst_n || rd_n)
                    rd_cnt <= '0;
                else if (rd_cnt != WLIM)
                    rd_cnt <= rd_cnt + 1'b1;
            end

            // Wait while a shadowing read is inside its window.
            always_comb ready = !((mode == MODE_UNDER) && !rd_n && (rd_cnt < WLIM));
        end
    endgenerate

    // R8
    run_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN) |-> ready);

    // R7
    read_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_n) && mode == MODE_UNDER && WAIT_STATES > 0) |-> !ready);
endmodule

// File: rtl/sbc_strobe_mux.sv
// Steers CPU strobes onto ROM/RAM enables according to the mode.
// Purely combinational; assumes active-low strobes.
module sbc_strobe_mux
    import sbc_pkg::*;
(
    input  sbc_mode_t mode,
    input  logic      rd_n,
    input  logic      we_n,
    output logic      rom_oe_n,
    output logic      ram_oe_n,
    output logic      ram_we_n
);
    // Select the strobe routing for the current mode.
    always_comb begin
        if (mode == MODE_UNDER) begin
            rom_oe_n = rd_n;
            ram_we_n = rd_n;
            ram_oe_n = 1'b1;
        end else begin
            rom_oe_n = 1'b1;
            ram_we_n = we_n;
            ram_oe_n = rd_n;
        end
    end
endmodule

// File: rtl/shadow_boot_ctrl.sv
// Top of the boot ROM shadowing controller: mode register, strobe
// steering and ROM wait generation. Assumes one clock domain and a
// control bit held steady by an external output latch.
module shadow_boot_ctrl
    import sbc_pkg::*;
#(
    parameter int WAIT_STATES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_n,
    input  logic we_n,
    input  logic run_sel,
    output logic rom_oe_n,
    output logic ram_oe_n,
    output logic ram_we_n,
    output logic ready
);
    sbc_mode_t mode;

    sbc_mode_reg u_mode (
        .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .we_n(we_n),
        .run_sel(run_sel), .mode(mode)
    );

    sbc_strobe_mux u_mux (
        .mode(mode), .rd_n(rd_n), .we_n(we_n),
        .rom_oe_n(rom_oe_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n)
    );

    sbc_wait_gen #(.WAIT_STATES(WAIT_STATES)) u_wait (
        .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .mode(mode), .ready(ready)
    );

    // R10
    oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rom_oe_n && !ram_oe_n));

    // R4
    run_rom_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN) |-> rom_oe_n);

    // R5
    enter_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n && we_n && run_sel) |=> (mode == MODE_RUN));
endmodule

// File: tb/shadow_boot_ctrl_tb.sv
module shadow_boot_ctrl_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_n = 1'b1;
    logic we_n = 1'b1;
    logic run_sel = 1'b0;
    logic rom_oe_n, ram_oe_n, ram_we_n, ready;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    shadow_boot_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .we_n(we_n), .run_sel(run_sel),
        .rom_oe_n(rom_oe_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n), .ready(ready)
    );

    // Compare {rom_oe_n, ram_oe_n, ram_we_n, ready} against an expected value.
    task automatic chk(input logic [3:0] exp, input string req);
        logic [3:0] act;
        act = {rom_oe_n, ram_oe_n, ram_we_n, ready};
        n_tests++;
        if (act !== exp || (!rom_oe_n && !ram_oe_n)) begin
            n_fail++;
            $display("FAIL %s: {rom_oe_n,ram_oe_n,ram_we_n,ready} act=%b exp=%b", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Shadowing read: one wait clock, then ready; RAM written by read strobe.
    task automatic t_under_read(input string req);
        step(); rd_n = 1'b0; #1 chk(4'b0100, req);
        step(); #1 chk(4'b0101, req);
        step(); #1 chk(4'b0101, req);
        rd_n = 1'b1; #1 chk(4'b1111, req);
    endtask

    // Run-mode read and write.
    task automatic t_run_access(input string req);
        step(); rd_n = 1'b0; #1 chk(4'b1011, req);
        step(); #1 chk(4'b1011, req);
        rd_n = 1'b1; #1 chk(4'b1111, req);
        step(); we_n = 1'b0; #1 chk(4'b1101, req);
        step(); we_n = 1'b1; #1 chk(4'b1111, req);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        rd_n = 1'b0; #1 chk(4'b0100, "R1 in reset");
        rd_n = 1'b1;
        step(); rst_n = 1'b1; #1 chk(4'b1111, "R1 idle");
        t_under_read("R1 R2 R7 first read");
    endtask

    task automatic t_under_write();
        step(); we_n = 1'b0; #1 chk(4'b1111, "R3 write ignored");
        step(); #1 chk(4'b1111, "R3 write ignored");
        we_n = 1'b1;
    endtask

    task automatic t_enter_run();
        step(); run_sel = 1'b1;
        step();
        t_run_access("R4 R5 R8 run");
    endtask

    task automatic t_back_under();
        step(); run_sel = 1'b0;
        step();
        t_under_read("R6 back to shadowing");
    endtask

    task automatic t_deferred();
        step(); rd_n = 1'b0; run_sel = 1'b1; #1 chk(4'b0100, "R9 request mid-read");
        step(); #1 chk(4'b0101, "R9 still shadowing");
        step(); #1 chk(4'b0101, "R9 still shadowing");
        rd_n = 1'b1;
        step(); rd_n = 1'b0; #1 chk(4'b1011, "R9 R5 run after idle");
        step(); rd_n = 1'b1;
    endtask

    task automatic t_reset_in_run();
        step(); rst_n = 1'b0;
        step(); rd_n = 1'b0; #1 chk(4'b0100, "R11 reset over run request");
        step(); rd_n = 1'b1; run_sel = 1'b0;
        step(); rst_n = 1'b1;
        t_under_read("R11 R2 after reset");
    endtask

    initial begin
        t_reset();
        t_under_write();
        t_enter_run();
        t_back_under();
        t_deferred();
        t_reset_in_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: act=timeout exp=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule